// File: doc/BRIEF.md
# Packed Multiply-Accumulate Unit with Widened Accumulator

This unit takes commands that pack several small integers into 64-bit operands and accumulates the results in a private 192-bit register. The register is split into lanes that are three times as wide as the operand lanes. With 16-bit operand lanes it holds four 48-bit lanes. With 8-bit operand lanes it holds eight 24-bit lanes. Each accumulate command either multiplies the matching lanes of its two operands or adds them, and adds that per-lane term into the wide lane. Sums of many storage-width terms therefore stay exact until the very wide limit is reached.

The accumulator is visible only through a retrieve command. A retrieve shifts every wide lane right by an amount given in the command. It then clamps each lane to the operand lane width and returns the lanes packed into one 64-bit word on the result port. A clear command zeroes the whole register. Commands use a valid/ready handshake. The unit is not ready for one cycle after it accepts a retrieve, which is the cycle in which it presents the result.

Top module: `pmac_unit`

## Requirements
- R1: After reset the accumulator is all zero, `res_valid` is low and `cmd_ready` is high.
- R2: Opcode 2'b01 (multiply) with `cmd_narrow`=0 treats bits [16i+15:16i] of each operand as signed two's-complement lane i (i=0..3). It adds the signed product into 48-bit accumulator lane i, modulo 2^48.
- R3: Opcode 2'b01 with `cmd_narrow`=1 treats bits [8i+7:8i] as unsigned lane i (i=0..7). It adds the unsigned product into 24-bit accumulator lane i, modulo 2^24.
- R4: Opcode 2'b10 (add) adds the lane sum a_i+b_i into accumulator lane i. Operands are sign-extended in 16-bit mode and zero-extended in 8-bit mode.
- R5: Lane accumulation does not wrap at storage width. Sums of many maximum-size terms are held exactly in the wide lanes.
- R6: Opcode 2'b11 (retrieve), when accepted on an edge, drives `res_valid` high for exactly the following cycle. Result lane i sits at the operand lane position and is computed from the accumulator value before that edge, shifted right by `cmd_shift`. The shift is arithmetic in 16-bit mode and logical in 8-bit mode.
- R7: Retrieve saturates each shifted lane. In 16-bit mode values above 32767 give 16'h7FFF and values below -32768 give 16'h8000. In 8-bit mode values above 255 give 8'hFF.
- R8: Opcode 2'b00 (clear) sets all 192 accumulator bits to zero.
- R9: `cmd_ready` is low in the cycle after a retrieve is accepted. A command presented in that cycle is ignored and leaves the accumulator unchanged.
- R10: A retrieve does not modify the accumulator, so back-to-back retrieves with the same shift return the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_op | input | 2 | 00 clear, 01 multiply, 10 add, 11 retrieve |
| cmd_narrow | input | 1 | 0: four 16-bit signed lanes; 1: eight 8-bit unsigned lanes |
| cmd_a | input | 64 | Packed operand A |
| cmd_b | input | 64 | Packed operand B |
| cmd_shift | input | 6 | Right shift applied per lane on retrieve |
| res_valid | output | 1 | Retrieve result valid (one cycle) |
| res_data | output | 64 | Packed, saturated retrieve result |

## Verification
A corrupted accumulator lane cannot be seen until the next retrieve, so the bench retrieves after short runs of accumulate commands. Errors in sign extension, lane slicing or the widened carry then show up within a few commands. Each retrieve is checked with several shift amounts, so faults in low and high accumulator bits reach the ports through the saturating readout and are not hidden by it. A handshake fault, such as an accepted command during the ready gap, shows at the next retrieve as a changed value.

// File: rtl/pmac_pkg.sv
package pmac_pkg;
  // Accumulator lane width is GROW times the operand lane width.
  localparam int GROW = 3;

  typedef enum logic [1:0] {
    OP_CLR = 2'b00,
    OP_MUL = 2'b01,
    OP_ADD = 2'b10,
    OP_RD  = 2'b11
  } pmac_op_e;
endpackage

// File: rtl/pmac_lane.sv
// One accumulator lane: next-value arithmetic and saturating readout.
module pmac_lane #(
  parameter int SW   = 16,
  parameter bit SGN  = 1'b1,
  parameter int SH_W = 6,
  localparam int AW  = pmac_pkg::GROW * SW
) (
  input  logic [AW-1:0]   acc_in,
  input  logic [SW-1:0]   op_a,
  input  logic [SW-1:0]   op_b,
  input  logic            is_mul,
  input  logic [SH_W-1:0] shift,
  output logic [AW-1:0]   acc_nxt,
  output logic [SW-1:0]   rd_lane
);
  logic [AW-1:0] ext_a, ext_b, term;

  // Widen both operands to accumulator width before any arithmetic.
  function automatic logic [AW-1:0] widen(input logic [SW-1:0] v);
    if (SGN) return {{(AW-SW){v[SW-1]}}, v};
    else     return {{(AW-SW){1'b0}}, v};
  endfunction

  always_comb begin
    ext_a   = widen(op_a);
    ext_b   = widen(op_b);
    term    = is_mul ? (ext_a * ext_b) : (ext_a + ext_b);
    acc_nxt = acc_in + term;
  end

  generate
    if (SGN) begin : g_signed
      logic signed [AW-1:0] shd;
      always_comb begin
        shd = $signed(acc_in) >>> shift;
        if (shd[AW-1:SW-1] == '0 || shd[AW-1:SW-1] == '1)
          rd_lane = shd[SW-1:0];
        else if (shd[AW-1])
          rd_lane = {1'b1, {(SW-1){1'b0}}};
        else
          rd_lane = {1'b0, {(SW-1){1'b1}}};
      end
    end else begin : g_unsigned
      logic [AW-1:0] shd;
      always_comb begin
        shd     = acc_in >> shift;
        rd_lane = (|shd[AW-1:SW]) ? {SW{1'b1}} : shd[SW-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/pmac_view.sv
// One lane-size view of the accumulator: OP_W/SW lanes side by side.
module pmac_view #(
  parameter int OP_W = 64,
  parameter int SW   = 16,
  parameter bit SGN  = 1'b1,
  parameter int SH_W = 6,
  localparam int NL  = OP_W / SW,
  localparam int AW  = pmac_pkg::GROW * SW,
  localparam int ACC_W = NL * AW
) (
  input  logic [ACC_W-1:0] acc_in,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic             is_mul,
  input  logic [SH_W-1:0]  shift,
  output logic [ACC_W-1:0] acc_nxt,
  output logic [OP_W-1:0]  rd_word
);
  for (genvar i = 0; i < NL; i++) begin : g_lane
    pmac_lane #(.SW(SW), .SGN(SGN), .SH_W(SH_W)) u_lane (
      .acc_in  (acc_in[i*AW +: AW]),
      .op_a    (op_a[i*SW +: SW]),
      .op_b    (op_b[i*SW +: SW]),
      .is_mul  (is_mul),
      .shift   (shift),
      .acc_nxt (acc_nxt[i*AW +: AW]),
      .rd_lane (rd_word[i*SW +: SW])
    );
  end
endmodule

// File: rtl/pmac_unit.sv
module pmac_unit #(
  parameter int OP_W      = 64,
  parameter int WIDE_SW   = 16,
  parameter int NARROW_SW = 8,
  parameter int SH_W      = 6,
  localparam int ACC_W    = pmac_pkg::GROW * OP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic            cmd_narrow,
  input  logic [OP_W-1:0] cmd_a,
  input  logic [OP_W-1:0] cmd_b,
  input  logic [SH_W-1:0] cmd_shift,
  output logic            res_valid,
  output logic [OP_W-1:0] res_data
);
  import pmac_pkg::*;

  logic [ACC_W-1:0] acc_q, nxt_wide, nxt_narrow;
  logic [OP_W-1:0]  rd_wide, rd_narrow, res_q;
  logic             res_valid_q;
  pmac_op_e         op;

  // Named internal events, also observed by the checker.
  logic accept, acc_fire, rd_fire, clr_fire, is_mul;

  always_comb begin
    op        = pmac_op_e'(cmd_op);
    cmd_ready = !res_valid_q;
    accept    = cmd_valid && cmd_ready;
    is_mul    = (op == OP_MUL);
    acc_fire  = accept && (op == OP_MUL || op == OP_ADD);
    rd_fire   = accept && (op == OP_RD);
    clr_fire  = accept && (op == OP_CLR);
  end

  pmac_view #(.OP_W(OP_W), .SW(WIDE_SW), .SGN(1'b1), .SH_W(SH_W)) u_wide (
    .acc_in (acc_q), .op_a (cmd_a), .op_b (cmd_b), .is_mul (is_mul),
    .shift (cmd_shift), .acc_nxt (nxt_wide), .rd_word (rd_wide)
  );

  pmac_view #(.OP_W(OP_W), .SW(NARROW_SW), .SGN(1'b0), .SH_W(SH_W)) u_narrow (
    .acc_in (acc_q), .op_a (cmd_a), .op_b (cmd_b), .is_mul (is_mul),
    .shift (cmd_shift), .acc_nxt (nxt_narrow), .rd_word (rd_narrow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      res_valid_q <= 1'b0;
      res_q       <= '0;
    end else begin
      res_valid_q <= rd_fire;
      if (rd_fire)
        res_q <= cmd_narrow ? rd_narrow : rd_wide;
      if (clr_fire)
        acc_q <= '0;
      else if (acc_fire)
        acc_q <= cmd_narrow ? nxt_narrow : nxt_wide;
    end
  end

  assign res_valid = res_valid_q;
  assign res_data  = res_q;
endmodule

// File: rtl/pmac_chk.sv
module pmac_chk #(
  parameter int ACC_W = 192
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_ready,
  input logic             res_valid,
  input logic             acc_fire,
  input logic             rd_fire,
  input logic             clr_fire,
  input logic [ACC_W-1:0] acc_q
);
  // R8: clear leaves an all-zero accumulator
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> (acc_q == '0));

  // R9: ready gap follows an accepted retrieve
  p_ready_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> !cmd_ready);

  // R9: with no accepted update the accumulator keeps its value
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_fire || clr_fire) |=> $stable(acc_q));

  // R6: result valid follows the retrieve
  p_result_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> res_valid);

  // R6: result valid lasts a single cycle
  p_result_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R10: retrieve leaves the accumulator untouched
  p_read_keeps_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> $stable(acc_q));

  // R6: at most one kind of command is accepted per cycle
  p_one_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_fire, rd_fire, clr_fire}));
endmodule

bind pmac_unit pmac_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .res_valid (res_valid),
  .acc_fire  (acc_fire),
  .rd_fire   (rd_fire),
  .clr_fire  (clr_fire),
  .acc_q     (acc_q)
);

// File: tb/pmac_unit_tb_top.sv
`timescale 1ns/1ps
module pmac_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b00;
  logic        cmd_narrow = 1'b0;
  logic [63:0] cmd_a = '0, cmd_b = '0;
  logic [5:0]  cmd_shift = '0;
  logic        res_valid;
  logic [63:0] res_data;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // Bench-side model of the accumulator lanes.
  logic signed [47:0] m16 [4];
  logic        [23:0] m8  [8];

  always #10 clk = ~clk;  // 50 MHz

  pmac_unit dut_i (
    .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
    .cmd_op (cmd_op), .cmd_narrow (cmd_narrow), .cmd_a (cmd_a), .cmd_b (cmd_b),
    .cmd_shift (cmd_shift), .res_valid (res_valid), .res_data (res_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sat16(input logic signed [47:0] v, input int sh);
    logic signed [47:0] s;
    s = v >>> sh;
    if (s > 48'sd32767) return 16'h7FFF;
    if (s < -48'sd32768) return 16'h8000;
    return s[15:0];
  endfunction

  function automatic logic [7:0] sat8(input logic [23:0] v, input int sh);
    logic [23:0] s;
    s = v >> sh;
    return (s > 24'd255) ? 8'hFF : s[7:0];
  endfunction

  function automatic logic [63:0] expect_word(input bit narrow, input int sh);
    logic [63:0] w;
    w = '0;
    if (narrow) for (int i = 0; i < 8; i++) w[8*i +: 8] = sat8(m8[i], sh);
    else        for (int i = 0; i < 4; i++) w[16*i +: 16] = sat16(m16[i], sh);
    return w;
  endfunction

  function automatic logic [63:0] pat(input int k, input int salt);
    logic [63:0] v;
    v = 64'(k + 1) * 64'h9E37_79B9_7F4A_7C15 + 64'(salt) * 64'hC2B2_AE3D_27D4_EB4F;
    if (k % 7 == 0) v = 64'h8000_7FFF_FFFF_0001;
    return v;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 4; i++) m16[i] = '0;
    for (int i = 0; i < 8; i++) m8[i] = '0;
  endtask

  task automatic model_step(input bit mul, input bit narrow, input logic [63:0] a, input logic [63:0] b);
    if (narrow) begin
      for (int i = 0; i < 8; i++) begin
        logic [7:0] x, y;
        x = a[8*i +: 8]; y = b[8*i +: 8];
        m8[i] = m8[i] + (mul ? 24'(x) * 24'(y) : 24'(x) + 24'(y));
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        logic signed [15:0] x, y;
        logic signed [47:0] t;
        x = a[16*i +: 16]; y = b[16*i +: 16];
        t = mul ? (48'(x) * 48'(y)) : (48'(x) + 48'(y));
        m16[i] = m16[i] + t;
      end
    end
  endtask

  // Issue one command at a negedge; ready is high in these cycles.
  task automatic issue(input logic [1:0] op, input bit narrow, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_narrow = narrow; cmd_a = a; cmd_b = b;
    @(posedge clk);
    if (op == 2'b00) model_clear();
    else model_step(op == 2'b01, narrow, a, b);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Retrieve; optionally present a stray multiply during the ready gap.
  task automatic retrieve(input string req, input bit narrow, input int sh, input bit stray);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b11; cmd_narrow = narrow; cmd_shift = 6'(sh);
    @(posedge clk);
    @(negedge clk);
    check({req, " result"}, res_data, expect_word(narrow, sh));
    check({req, " res_valid/ready (R6 R9)"}, {62'd0, res_valid, cmd_ready}, 64'd2);
    if (stray) begin
      cmd_op = 2'b01; cmd_a = 64'h7FFF_7FFF_7FFF_7FFF; cmd_b = 64'h7FFF_7FFF_7FFF_7FFF;
    end else cmd_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check({req, " pulse ends (R6)"}, {62'd0, res_valid, cmd_ready}, 64'd1);
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check("R1 reset ready/valid", {62'd0, res_valid, cmd_ready}, 64'd1);
    rst_n = 1'b1;
    retrieve("R1 reset accumulator wide", 1'b0, 0, 1'b0);
    retrieve("R1 reset accumulator narrow", 1'b1, 0, 1'b0);

    // R2: signed 16-bit multiply sweep, checked at several shifts.
    issue(2'b00, 1'b0, '0, '0);
    for (int k = 0; k < 64; k++) begin
      issue(2'b01, 1'b0, pat(k, 1), pat(k, 2));
      if (k % 8 == 7) begin
        retrieve("R2 wide mul sh0", 1'b0, 0, 1'b0);
        retrieve("R2 wide mul sh20", 1'b0, 20, 1'b0);
        retrieve("R2 wide mul sh31", 1'b0, 31, 1'b0);
        retrieve("R2 wide mul sh63", 1'b0, 63, 1'b0);
      end
    end

    // R4: add mode in 16-bit lanes, mixed with multiplies.
    issue(2'b00, 1'b0, '0, '0);
    for (int k = 0; k < 48; k++) begin
      issue((k % 3 == 0) ? 2'b01 : 2'b10, 1'b0, pat(k, 5), pat(k, 9));
      if (k % 6 == 5) begin
        retrieve("R4 wide add sh0", 1'b0, 0, 1'b0);
        retrieve("R4 wide add sh3", 1'b0, 3, 1'b0);
      end
    end

    // R7: saturation corners in 16-bit lanes.
    issue(2'b00, 1'b0, '0, '0);
    issue(2'b01, 1'b0, {16'hFFFE, 16'd3, 16'h8000, 16'h7FFF},
                       {16'd3,    16'd5, 16'h7FFF, 16'h7FFF});
    retrieve("R7 wide saturate sh0", 1'b0, 0, 1'b0);
    check("R7 wide corner constant", res_data, 64'hFFFA_000F_8000_7FFF);
    retrieve("R7 wide sh14", 1'b0, 14, 1'b0);

    // R3: unsigned 8-bit multiply sweep over every byte value per lane.
    issue(2'b00, 1'b1, '0, '0);
    for (int k = 0; k < 256; k++) begin
      logic [63:0] a, b;
      for (int i = 0; i < 8; i++) begin
        a[8*i +: 8] = 8'(k + 32*i);
        b[8*i +: 8] = 8'(255 - 3*k + 17*i);
      end
      issue(2'b01, 1'b1, a, b);
      if (k % 32 == 31) begin
        retrieve("R3 narrow mul sh0", 1'b1, 0, 1'b0);
        retrieve("R3 narrow mul sh9", 1'b1, 9, 1'b0);
        retrieve("R3 narrow mul sh16", 1'b1, 16, 1'b0);
      end
    end

    // R4: add mode in 8-bit lanes (zero extension).
    issue(2'b00, 1'b1, '0, '0);
    for (int k = 0; k < 40; k++) begin
      issue((k % 4 == 0) ? 2'b01 : 2'b10, 1'b1, pat(k, 11), pat(k, 13));
      if (k % 10 == 9) begin
        retrieve("R4 narrow add sh0", 1'b1, 0, 1'b0);
        retrieve("R4 narrow add sh4", 1'b1, 4, 1'b0);
      end
    end
    issue(2'b00, 1'b1, '0, '0);
    issue(2'b10, 1'b1, {8{8'hFF}}, {8{8'h80}});
    retrieve("R4 narrow add no sign", 1'b1, 1, 1'b0);
    check("R4 narrow 0x17F>>1", res_data, {8{8'hBF}});

    // R5: 250 products of 255*255 fit in 24-bit lanes.
    issue(2'b00, 1'b1, '0, '0);
    for (int k = 0; k < 250; k++) issue(2'b01, 1'b1, {8{8'hFF}}, {8{8'hFF}});
    retrieve("R5 narrow wide sum sh16", 1'b1, 16, 1'b0);
    check("R5 narrow 16256250>>16", res_data, {8{8'd248}});
    // R5: 64 products of (-32768)^2 fit in 48-bit lanes.
    issue(2'b00, 1'b0, '0, '0);
    for (int k = 0; k < 64; k++) issue(2'b01, 1'b0, {4{16'h8000}}, {4{16'h8000}});
    retrieve("R5 wide sum sh30", 1'b0, 30, 1'b0);
    check("R5 wide 2^36>>30", res_data, {4{16'd64}});

    // R9 and R10: stray command in the ready gap, back-to-back reads.
    retrieve("R9 gap read", 1'b0, 24, 1'b1);
    retrieve("R9 stray ignored", 1'b0, 24, 1'b0);
    check("R10 repeat read", res_data, {4{16'd4096}});

    // R8: clear from a loaded state, seen in both views.
    issue(2'b00, 1'b0, '0, '0);
    retrieve("R8 cleared wide", 1'b0, 0, 1'b0);
    check("R8 cleared constant", res_data, 64'd0);
    retrieve("R8 cleared narrow", 1'b1, 0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule